// File: doc/BRIEF.md
# Multi-Queue Inter-Processor Mailbox

This block lets processors on a chip hand each other 32-bit messages through a set of independent first-in first-out queues. Every queue shows three word-sized registers on a plain single-cycle register bus: a message window, a fill-count word and a full flag. A write to the message window appends a word to the tail of that queue. A read of the same window returns the oldest word and removes it.

A receiver empties a queue by reading the message window until the count word reads zero. A sender looks at the full flag before it writes. Each queue also drives two level signals towards an interrupt unit: one says a message is waiting, and the other says there is room for another word.

The number of queues and the depth of each queue are parameters. A read-only identification word sits at offset zero. Read data is combinational within the bus cycle, and queue state changes on the clock edge that ends that cycle.

Top module: `mbx_array`

## Requirements
- R1: A read at byte offset 0x000 returns the parameter REV_ID. A write to that offset changes no register.
- R2: A write to offset 0x040 + 4*q (q below NQ) appends busWdata to queue q. A read of that offset returns the oldest stored word of queue q and removes it, so the words come out in the order they were written.
- R3: A read at offset 0x080 + 4*q returns 1 when queue q holds DEPTH words and 0 otherwise.
- R4: A read at offset 0x0C0 + 4*q returns the number of unread words in queue q, zero-extended. It reads 0 exactly when the queue is empty.
- R5: A write to the message window of a full queue is dropped. The queue keeps its contents, its order and its count.
- R6: A read of the message window of an empty queue returns the word most recently removed from that queue, or 0 if none has been removed since reset. It changes no state.
- R7: newMsg[q] is 1 exactly while queue q holds at least one word.
- R8: notFull[q] is 1 exactly while queue q holds fewer than DEPTH words.
- R9: Reset empties every queue and clears every count.
- R10: An operation on one queue leaves the count and contents of every other queue unchanged.
- R11: A read of any other offset returns 0, and a write there has no effect. This includes misaligned offsets, offsets above 0x0FF and windows of queues with index NQ or higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the access |
| newMsg | output | NQ | Per-queue message-waiting level |
| notFull | output | NQ | Per-queue room-available level |

## Verification
Read data is combinational, so the bench drives each access just after a falling edge and samples busRdata two nanoseconds later, before the rising edge that commits a pop. A push or pop takes effect on that rising edge. The count, the full flag and both event levels therefore first show the new value one clock after the access, and the bench reads them only after the next falling edge. The sweep fills every queue past full and drains it past empty, then interleaves queues, comparing every result with a per-queue model kept in the bench.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // queue index field: four bits, since each window spans 64 bytes at stride 4
  localparam int QIDX_W = 4;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_REV,
    RK_MSG,
    RK_FULL,
    RK_CNT
  } regKind_e;

  typedef struct packed {
    logic             push;
    logic             pop;
    regKind_e         kind;
    logic [QIDX_W-1:0] q;
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int ADDR_W = 12
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output mbxStrobe_t        strb
);
  localparam logic [QIDX_W:0] NQ_L = (QIDX_W+1)'(NQ);

  logic [QIDX_W-1:0] qIdx;
  logic              inRange;
  logic              mapped;

  assign qIdx    = busAddr[5:2];
  assign inRange = {1'b0, qIdx} < NQ_L;
  assign mapped  = busSel && (busAddr[1:0] == 2'b00) &&
                   (busAddr[ADDR_W-1:8] == '0);

  always_comb begin
    strb      = '0;
    strb.kind = RK_NONE;
    strb.q    = qIdx;
    if (mapped) begin
      unique case (busAddr[7:6])
        2'd0: if (qIdx == '0) strb.kind = RK_REV;
        2'd1: if (inRange) strb.kind = RK_MSG;
        2'd2: if (inRange) strb.kind = RK_FULL;
        default: if (inRange) strb.kind = RK_CNT;
      endcase
    end
    strb.push = (strb.kind == RK_MSG) && busWr;
    strb.pop  = (strb.kind == RK_MSG) && !busWr;
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int          NQ     = 4,
  parameter int          DEPTH  = 4,
  parameter logic [31:0] REV_ID = 32'h0001_0200
) (
  input  logic             clk,
  input  logic             rstN,
  input  mbxStrobe_t       strb,
  input  logic             busWr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  output logic [NQ-1:0]    newMsg,
  output logic [NQ-1:0]    notFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] qCnt  [NQ];
  logic [31:0]      qHead [NQ];
  logic [31:0]      qLast [NQ];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < NQ; i++) begin : g_queue
    logic [31:0]      mem [DEPTH];
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [CNT_W-1:0] cnt;
    logic [31:0]      lastPop;
    logic             sel, doPush, doPop;

    assign sel    = (int'(strb.q) == i);
    assign doPush = sel && strb.push && (cnt != FULL_CNT);
    assign doPop  = sel && strb.pop && (cnt != '0);

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= busWdata;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        cnt     <= '0;
        lastPop <= '0;
      end else begin
        if (doPush) begin
          wrPtr <= nextPtr(wrPtr);
          cnt   <= cnt + 1'b1;
        end
        if (doPop) begin
          rdPtr   <= nextPtr(rdPtr);
          cnt     <= cnt - 1'b1;
          lastPop <= mem[rdPtr];
        end
      end
    end

    assign qCnt[i]    = cnt;
    assign qHead[i]   = mem[rdPtr];
    assign qLast[i]   = lastPop;
    assign newMsg[i]  = (cnt != '0);
    assign notFull[i] = (cnt != FULL_CNT);
  end

  always_comb begin
    busRdata = '0;
    if (!busWr) begin
      for (int i = 0; i < NQ; i++) begin
        if (int'(strb.q) == i) begin
          unique case (strb.kind)
            RK_MSG:  busRdata = (qCnt[i] != '0) ? qHead[i] : qLast[i];
            RK_FULL: busRdata = {31'b0, qCnt[i] == FULL_CNT};
            RK_CNT:  busRdata = 32'(qCnt[i]);
            default: ;
          endcase
        end
      end
      if (strb.kind == RK_REV) busRdata = REV_ID;
    end
  end
endmodule

// File: rtl/mbx_array.sv
module mbx_array
  import mbx_pkg::*;
#(
  parameter int          NQ     = 4,
  parameter int          DEPTH  = 4,
  parameter int          ADDR_W = 12,
  parameter logic [31:0] REV_ID = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NQ-1:0]     newMsg,
  output logic [NQ-1:0]     notFull
);
  mbxStrobe_t strb;

  mbx_ctrl #(.NQ(NQ), .ADDR_W(ADDR_W)) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  mbx_datapath #(.NQ(NQ), .DEPTH(DEPTH), .REV_ID(REV_ID)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busWr   (busWr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .newMsg  (newMsg),
    .notFull (notFull)
  );
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int          NQ     = 4,
  parameter int          ADDR_W = 12,
  parameter logic [31:0] REV_ID = 32'h0001_0200
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic [NQ-1:0]     newMsg,
  input logic [NQ-1:0]     notFull
);
  // R1
  rev_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == '0) |-> busRdata == REV_ID);

  // R9
  reset_empty_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (newMsg == '0 && notFull == '1));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    localparam logic [ADDR_W-1:0] MSG_A  = ADDR_W'(12'h040 + 4*q);
    localparam logic [ADDR_W-1:0] FULL_A = ADDR_W'(12'h080 + 4*q);
    localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(12'h0C0 + 4*q);

    // R2
    push_arrives_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && busAddr == MSG_A && !newMsg[q]) |=> newMsg[q]);

    // R3
    full_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && !busWr && busAddr == FULL_A) |-> busRdata == {31'b0, !notFull[q]});

    // R4
    count_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && !busWr && busAddr == CNT_A) |-> ((busRdata == 0) == !newMsg[q]));

    // R5
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && busWr && busAddr == MSG_A && !notFull[q]) |=> !notFull[q]);

    // R6
    empty_read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && !busWr && busAddr == MSG_A && !newMsg[q]) |=> (!newMsg[q] && notFull[q]));

    // R8
    levels_consistent_chk: assert property (@(posedge clk) disable iff (!rstN)
      !notFull[q] |-> newMsg[q]);
  end
endmodule

bind mbx_array mbx_chk #(.NQ(NQ), .ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .newMsg  (newMsg),
  .notFull (notFull)
);

// File: tb/sim_mbx_array.sv
module sim_mbx_array;
  localparam int          NQ     = 4;
  localparam int          DEPTH  = 4;
  localparam int          ADDR_W = 12;
  localparam logic [31:0] REV_ID = 32'h0001_0200;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [NQ-1:0]     newMsg;
  logic [NQ-1:0]     notFull;

  int nTests = 0;
  int nFail  = 0;

  logic [31:0] mBuf  [NQ][DEPTH];
  int          mCnt  [NQ];
  logic [31:0] mLast [NQ];

  always #4 clk = ~clk;

  mbx_array #(.NQ(NQ), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .REV_ID(REV_ID)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .newMsg(newMsg), .notFull(notFull)
  );

  function automatic logic [ADDR_W-1:0] msgA(int q);  return ADDR_W'(12'h040 + 4*q); endfunction
  function automatic logic [ADDR_W-1:0] fullA(int q); return ADDR_W'(12'h080 + 4*q); endfunction
  function automatic logic [ADDR_W-1:0] cntA(int q);  return ADDR_W'(12'h0C0 + 4*q); endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #2 d = busRdata;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic modelPush(int q, logic [31:0] d);
    if (mCnt[q] < DEPTH) begin
      mBuf[q][mCnt[q]] = d;
      mCnt[q]++;
    end
  endtask

  task automatic modelPop(int q, output logic [31:0] d);
    if (mCnt[q] == 0) d = mLast[q];
    else begin
      d = mBuf[q][0];
      for (int k = 0; k < DEPTH - 1; k++) mBuf[q][k] = mBuf[q][k+1];
      mCnt[q]--;
      mLast[q] = d;
    end
  endtask

  task automatic checkQueue(int q, string tagC);
    logic [31:0] r;
    busRead(cntA(q), r);
    check({tagC, " R4 count"}, r, 32'(mCnt[q]));
    busRead(fullA(q), r);
    check({tagC, " R3 full"}, r, {31'b0, mCnt[q] == DEPTH});
    #1;
    check({tagC, " R7 newMsg"}, {31'b0, newMsg[q]}, {31'b0, mCnt[q] != 0});
    check({tagC, " R8 notFull"}, {31'b0, notFull[q]}, {31'b0, mCnt[q] != DEPTH});
  endtask

  task automatic checkAll(string tagC);
    for (int q = 0; q < NQ; q++) checkQueue(q, tagC);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] r, e;
    for (int q = 0; q < NQ; q++) begin mCnt[q] = 0; mLast[q] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    checkAll("R9 reset");
    for (int q = 0; q < NQ; q++) begin
      busRead(msgA(q), r);
      check("R6 empty read after reset", r, 32'h0);
    end

    // R1: revision read, write ignored
    busRead('0, r);
    check("R1 revision", r, REV_ID);
    busWrite('0, 32'hDEAD_BEEF);
    busRead('0, r);
    check("R1 revision after write", r, REV_ID);

    // R2, R5, R6, R10: fill each queue past full, drain past empty
    for (int q = 0; q < NQ; q++) begin
      for (int k = 0; k <= DEPTH; k++) begin
        e = 32'h1000_0000 * (q + 1) + 32'(k * 17 + 3);
        busWrite(msgA(q), e);
        modelPush(q, e);
        checkAll("R10 fill");
      end
      checkQueue(q, "R5 after overfill");
      for (int k = 0; k <= DEPTH; k++) begin
        busRead(msgA(q), r);
        modelPop(q, e);
        check(k == DEPTH ? "R6 empty read repeats last" : "R2 order", r, e);
        checkQueue(q, "R2 drain");
      end
      busRead(msgA(q), r);
      check("R6 second empty read", r, mLast[q]);
      checkQueue(q, "R6 state unchanged");
    end

    // R10: interleave two queues with wrapping pointers
    for (int k = 0; k < 3 * DEPTH; k++) begin
      busWrite(msgA(0), 32'hA000 + 32'(k));
      modelPush(0, 32'hA000 + 32'(k));
      busWrite(msgA(2), 32'hB000 + 32'(k));
      modelPush(2, 32'hB000 + 32'(k));
      if (k % 2 == 1) begin
        busRead(msgA(2), r); modelPop(2, e);
        check("R10 interleave q2", r, e);
        busRead(msgA(0), r); modelPop(0, e);
        check("R10 interleave q0", r, e);
      end
      checkAll("R10 interleave");
    end

    // R11: unmapped, misaligned and out-of-range windows
    busWrite(ADDR_W'(12'h040 + 4*NQ), 32'h5555_5555);
    busWrite(ADDR_W'(12'h141), 32'h6666_6666);
    busWrite(msgA(1) | 12'h001, 32'h7777_7777);
    checkAll("R11 stray writes");
    busRead(ADDR_W'(12'h0C0 + 4*NQ), r);
    check("R11 out-of-range count", r, 32'h0);
    busRead(ADDR_W'(12'h004), r);
    check("R11 unmapped low", r, 32'h0);
    busRead(ADDR_W'(12'h140), r);
    check("R11 above window", r, 32'h0);
    busRead(msgA(0) | 12'h002, r);
    check("R11 misaligned", r, 32'h0);
    checkAll("R11 stray reads");

    // R9: reset in the middle of traffic
    busWrite(msgA(3), 32'h1234_5678);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int q = 0; q < NQ; q++) begin mCnt[q] = 0; mLast[q] = '0; end
    checkAll("R9 second reset");
    busRead(msgA(0), r);
    check("R9 last value cleared", r, 32'h0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule